// File: doc/BRIEF.md
# Dual-Side Mailbox Register Port

This block lets a processor core and an external host exchange 16-bit words through six shared mailbox slots. The core reaches the slots, a flag word and a control word through an eight-word window in its data address space. The host reaches the same eight words through a small synchronous request/acknowledge bus. At build time the host bus is either 16 bits wide or 8 bits wide with a byte-select address bit.

Each slot has two flags, one per direction. A flag records that one side has placed a word the other side has not yet taken. The other side clears it by reading the slot. The control word holds a writable overwrite enable and a self-clearing software-reset command. With overwrite disabled, a writer that targets a slot whose flag is still set is held off, through its acknowledge, until the reader has taken the old word. An 8-bit host can read the core-side flags through the low byte of the control word, so both directions of flags are visible through byte reads.

Top module: `dual_mailbox`

## Requirements
- R1: After reset every flag is zero, overwrite is one and every slot holds zero, so the flag word reads 0x0000 and the control word reads 0x0080.
- R2: On the core side, slots 0..5 are at WIN_BASE+0..5 (default 0x3FE0..0x3FE5), the flag word is at WIN_BASE+6 and the control word is at WIN_BASE+7. On a 16-bit host, the same words are at host offsets 0..7.
- R3: Flag word layout: bits 0..5 are the host-written flags of slots 0..5, bits 8..13 are the core-written flags of slots 0..5, and all other bits read zero.
- R4: Control word layout: bits 0..5 always equal the core-written flags, bit 6 (software reset) reads zero, bit 7 is overwrite, and bits 8..15 read zero.
- R5: A completed write of slot n sets the writer's flag n. A read of slot n by the opposite side clears it. A read by the writer's own side leaves it unchanged.
- R6: With overwrite at one, a write to a slot whose flag is set is acknowledged in the same cycle and replaces the word.
- R7: With overwrite at zero, a write to a slot whose own-side flag is set gets no acknowledge, and the slot keeps its word, until the other side reads that slot.
- R8: Writing the control word with bit 6 set clears all flags at the clock edge after the one that completes the write. An access completing in the cycle right after the write still sees the old flags. Slot words and overwrite are unaffected.
- R9: Only control bit 7 is writable. Writes to the flag word and to any other control bit have no effect.
- R10: When both sides write the same slot in the same cycle, the core's word is stored and both flags of that slot are set.
- R11: When one side's write and the other side's read of the same slot complete in the same cycle, the reader gets the old word and the flag ends set.
- R12: With HOST_DW=8, host address bits 3..1 select the word and bit 0 selects the byte (1 = high byte). Low-byte accesses move data but never change a flag. High-byte accesses set or clear flags as in R5.
- R13: A core access outside the window is acknowledged at once, changes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core access request, held until acknowledged |
| core_we | input | 1 | Core access is a write |
| core_addr | input | CORE_AW (14) | Core word address |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data, valid while the request is acknowledged |
| core_ack | output | 1 | Core access completes at the next rising edge |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 3 (4 when HOST_DW=8) | Host word address, plus byte select in 8-bit mode |
| host_wdata | input | HOST_DW (16) | Host write data |
| host_rdata | output | HOST_DW (16) | Host read data |
| host_ack | output | 1 | Host access completes at the next rising edge |

## Verification
The two functions that can land on the same clock edge are the core and host accesses to one slot. The bench starts both requests from the same falling edge in parallel threads. In one case both sides write the slot, and the slot's word plus both flag bits are then read back. In the other case one side writes while the other reads, and the read must return the old word while the flag word must still show the flag set. A software reset followed at once by a flag-word read covers the one-cycle lag between the command and the clearing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned SLOTS    = 6;
   localparam int unsigned WORD_W   = 16;
   localparam int unsigned IDX_W    = 3;
   localparam logic [IDX_W-1:0] FLAG_IDX = 3'd6;
   localparam logic [IDX_W-1:0] CTRL_IDX = 3'd7;
   localparam int unsigned OVW_POS  = 7;
   localparam int unsigned SRST_POS = 6;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [SLOTS-1:0]  slot_vec_t;

   function automatic slot_vec_t slot_onehot(input logic [IDX_W-1:0] idx, input logic en);
      slot_vec_t v;
      v = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (en && idx == IDX_W'(i)) v[i] = 1'b1;
      end
      return v;
   endfunction
endpackage

// File: rtl/mbx_win_decode.sv
module mbx_win_decode #(
   parameter int unsigned AW = 14,
   parameter logic [AW-1:0] BASE = '0
) (
   input  logic [AW-1:0]            addr,
   output logic                     hit,
   output logic [mbx_pkg::IDX_W-1:0] idx,
   output logic                     is_slot
);
   import mbx_pkg::*;

   generate
      if (AW < IDX_W) begin : g_bad_aw
         $error("window address must cover eight words");
      end
      if (BASE[IDX_W-1:0] != '0) begin : g_bad_base
         $error("window base must be aligned to eight words");
      end
      if (AW > IDX_W) begin : g_cmp
         assign hit = (addr[AW-1:IDX_W] == BASE[AW-1:IDX_W]);
      end else begin : g_all
         assign hit = 1'b1;
      end
   endgenerate

   assign idx     = addr[IDX_W-1:0];
   assign is_slot = (idx < IDX_W'(SLOTS));
endmodule

// File: rtl/mbx_flag_state.sv
module mbx_flag_state
   import mbx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  slot_vec_t c_set,
   input  slot_vec_t h_set,
   input  slot_vec_t c_rd,
   input  slot_vec_t h_rd,
   input  logic      ctrl_we,
   input  logic      ctrl_ovw,
   input  logic      ctrl_srst,
   output slot_vec_t cflag,
   output slot_vec_t hflag,
   output logic      ovw
);
   logic srst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         cflag  <= '0;
         hflag  <= '0;
         ovw    <= 1'b1;
      end else begin
         srst_q <= ctrl_we & ctrl_srst;
         if (ctrl_we) ovw <= ctrl_ovw;
         if (srst_q) begin
            cflag <= '0;
            hflag <= '0;
         end else begin
            cflag <= (cflag & ~h_rd) | c_set;
            hflag <= (hflag & ~c_rd) | h_set;
         end
      end
   end

   assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (cflag == '0 && hflag == '0));

   assert_ovw_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ovw) |-> $past(ctrl_we));

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_chk
         assert_cflag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cflag[i]) |-> $past(c_set[i]));
         assert_cflag_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cflag[i]) |-> $past(h_rd[i] || srst_q));
         assert_hflag_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hflag[i]) |-> $past(c_rd[i] || srst_q));
         assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (c_set[i] && h_rd[i] && !srst_q) |=> cflag[i]);
      end
   endgenerate
endmodule

// File: rtl/mbx_slot_bank.sv
module mbx_slot_bank
   import mbx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  slot_vec_t c_we,
   input  word_t     c_wdata,
   input  slot_vec_t h_we,
   input  logic [1:0] h_be,
   input  word_t     h_wdata,
   output word_t     slot_q [SLOTS]
);
   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[i] <= '0;
            end else if (c_we[i]) begin
               slot_q[i] <= c_wdata;
            end else if (h_we[i]) begin
               if (h_be[0]) slot_q[i][7:0]  <= h_wdata[7:0];
               if (h_be[1]) slot_q[i][15:8] <= h_wdata[15:8];
            end
         end

         assert_core_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            c_we[i] |=> (slot_q[i] == $past(c_wdata)));
      end
   endgenerate
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
   parameter int unsigned CORE_AW = 14,
   parameter logic [CORE_AW-1:0] WIN_BASE = 14'h3FE0,
   parameter int unsigned HOST_DW = 16,
   localparam int unsigned HAW = (HOST_DW == 8) ? 4 : 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               core_req,
   input  logic               core_we,
   input  logic [CORE_AW-1:0] core_addr,
   input  logic [15:0]        core_wdata,
   output logic [15:0]        core_rdata,
   output logic               core_ack,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HAW-1:0]     host_addr,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic [HOST_DW-1:0] host_rdata,
   output logic               host_ack
);
   import mbx_pkg::*;

   logic             c_hit, c_slot, h_hit, h_slot;
   logic [IDX_W-1:0] c_idx, h_idx;
   slot_vec_t        cflag, hflag, c_oh, h_oh;
   slot_vec_t        c_wr, c_rd, h_wr, h_set, h_clr;
   logic             ovw, c_stall, h_stall, c_done, h_done, c_ctl, h_ctl;
   logic [1:0]       h_be;
   logic             h_full;
   word_t            h_wword, c_word, h_word, flag_word, ctrl_word;
   word_t            slot_q [SLOTS];

   mbx_win_decode #(.AW(CORE_AW), .BASE(WIN_BASE)) u_cdec (
      .addr(core_addr), .hit(c_hit), .idx(c_idx), .is_slot(c_slot));

   mbx_win_decode #(.AW(IDX_W), .BASE(3'd0)) u_hdec (
      .addr(host_addr[HAW-1:HAW-IDX_W]), .hit(h_hit), .idx(h_idx), .is_slot(h_slot));

   // host lane variant: full-word access or byte access with high-byte commit
   generate
      if (HOST_DW == 16) begin : g_wide
         assign h_be       = 2'b11;
         assign h_wword    = host_wdata;
         assign h_full     = 1'b1;
         assign host_rdata = h_word;
      end else if (HOST_DW == 8) begin : g_byte
         logic h_hi;
         assign h_hi       = host_addr[0];
         assign h_be       = h_hi ? 2'b10 : 2'b01;
         assign h_wword    = {host_wdata, host_wdata};
         assign h_full     = h_hi;
         assign host_rdata = h_hi ? h_word[15:8] : h_word[7:0];
      end else begin : g_bad_dw
         $error("HOST_DW must be 8 or 16");
      end
   endgenerate

   // core side handshake
   assign c_oh     = slot_onehot(c_idx, c_hit & c_slot);
   assign c_stall  = core_req & core_we & ~ovw & (|(c_oh & cflag));
   assign core_ack = core_req & ~c_stall;
   assign c_done   = core_req & ~c_stall;
   assign c_wr     = c_oh & {SLOTS{c_done &  core_we}};
   assign c_rd     = c_oh & {SLOTS{c_done & ~core_we}};
   assign c_ctl    = c_done & core_we & c_hit & (c_idx == CTRL_IDX);

   // host side handshake
   assign h_oh     = slot_onehot(h_idx, h_hit & h_slot);
   assign h_stall  = host_req & host_we & ~ovw & (|(h_oh & hflag));
   assign host_ack = host_req & ~h_stall;
   assign h_done   = host_req & ~h_stall;
   assign h_wr     = h_oh & {SLOTS{h_done &  host_we}};
   assign h_set    = h_wr & {SLOTS{h_full}};
   assign h_clr    = h_oh & {SLOTS{h_done & ~host_we & h_full}};
   assign h_ctl    = h_done & host_we & h_hit & (h_idx == CTRL_IDX) & h_be[0];

   mbx_flag_state u_flags (
      .clk(clk), .rst_n(rst_n),
      .c_set(c_wr), .h_set(h_set), .c_rd(c_rd), .h_rd(h_clr),
      .ctrl_we(c_ctl | h_ctl),
      .ctrl_ovw(c_ctl ? core_wdata[OVW_POS] : h_wword[OVW_POS]),
      .ctrl_srst(c_ctl ? core_wdata[SRST_POS] : h_wword[SRST_POS]),
      .cflag(cflag), .hflag(hflag), .ovw(ovw));

   mbx_slot_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .c_we(c_wr), .c_wdata(core_wdata),
      .h_we(h_wr), .h_be(h_be), .h_wdata(h_wword),
      .slot_q(slot_q));

   assign flag_word = {2'b00, cflag, 2'b00, hflag};
   assign ctrl_word = {8'h00, ovw, 1'b0, cflag};

   always_comb begin
      c_word = '0;
      if (c_hit) begin
         if (c_idx == FLAG_IDX)      c_word = flag_word;
         else if (c_idx == CTRL_IDX) c_word = ctrl_word;
         else begin
            for (int i = 0; i < SLOTS; i++) if (c_idx == IDX_W'(i)) c_word = slot_q[i];
         end
      end
   end
   assign core_rdata = c_word;

   always_comb begin
      h_word = '0;
      if (h_idx == FLAG_IDX)      h_word = flag_word;
      else if (h_idx == CTRL_IDX) h_word = ctrl_word;
      else begin
         for (int i = 0; i < SLOTS; i++) if (h_idx == IDX_W'(i)) h_word = slot_q[i];
      end
   end

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_hold
         assert_core_unread_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovw && cflag[i] && !h_wr[i]) |=> $stable(slot_q[i]));
         assert_host_unread_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovw && hflag[i] && !c_wr[i]) |=> $stable(slot_q[i]));
      end
   endgenerate
endmodule

// File: tb/dual_mailbox_tb.sv
module dual_mailbox_tb;
   typedef struct { logic [15:0] v; string tag; } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        core_req = 0, core_we = 0, core_ack;
   logic [13:0] core_addr = '0;
   logic [15:0] core_wdata = '0, core_rdata;
   logic        host_req = 0, host_we = 0, host_ack;
   logic [2:0]  host_addr = '0;
   logic [15:0] host_wdata = '0, host_rdata;

   logic        c8_req = 0, c8_we = 0, c8_ack;
   logic [13:0] c8_addr = '0;
   logic [15:0] c8_wdata = '0, c8_rdata;
   logic        h8_req = 0, h8_we = 0, h8_ack;
   logic [3:0]  h8_addr = '0;
   logic [7:0]  h8_wdata = '0, h8_rdata;

   int n_cmp = 0, n_bad = 0;
   int w_c, w_h;
   exp_t cq[$], hq[$], c8q[$], h8q[$];
   localparam logic [13:0] B = 14'h3FE0;

   dual_mailbox u_dut (
      .clk(clk), .rst_n(rst_n),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
      .core_rdata(core_rdata), .core_ack(core_ack),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_ack(host_ack));

   dual_mailbox #(.HOST_DW(8)) u_dut8 (
      .clk(clk), .rst_n(rst_n),
      .core_req(c8_req), .core_we(c8_we), .core_addr(c8_addr), .core_wdata(c8_wdata),
      .core_rdata(c8_rdata), .core_ack(c8_ack),
      .host_req(h8_req), .host_we(h8_we), .host_addr(h8_addr), .host_wdata(h8_wdata),
      .host_rdata(h8_rdata), .host_ack(h8_ack));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic core_acc(input bit sel, input bit we, input logic [13:0] a,
                           input logic [15:0] d, output int waits);
      @(negedge clk);
      if (!sel) begin core_req = 1; core_we = we; core_addr = a; core_wdata = d; end
      else      begin c8_req = 1; c8_we = we; c8_addr = a; c8_wdata = d; end
      waits = 0;
      #1;
      while (!(sel ? c8_ack : core_ack)) begin waits++; @(negedge clk); #1; end
      @(posedge clk); #1;
      if (!sel) core_req = 0; else c8_req = 0;
   endtask

   task automatic host_acc(input bit sel, input bit we, input logic [3:0] a,
                           input logic [15:0] d, output int waits);
      @(negedge clk);
      if (!sel) begin host_req = 1; host_we = we; host_addr = a[2:0]; host_wdata = d; end
      else      begin h8_req = 1; h8_we = we; h8_addr = a; h8_wdata = d[7:0]; end
      waits = 0;
      #1;
      while (!(sel ? h8_ack : host_ack)) begin waits++; @(negedge clk); #1; end
      @(posedge clk); #1;
      if (!sel) host_req = 0; else h8_req = 0;
   endtask

   task automatic core_rd(input bit sel, input logic [13:0] a, input logic [15:0] e, input string tag);
      int w;
      exp_t it;
      it.v = e; it.tag = tag;
      if (!sel) cq.push_back(it); else c8q.push_back(it);
      core_acc(sel, 1'b0, a, 16'h0, w);
   endtask

   task automatic host_rd(input bit sel, input logic [3:0] a, input logic [15:0] e, input string tag);
      int w;
      exp_t it;
      it.v = e; it.tag = tag;
      if (!sel) hq.push_back(it); else h8q.push_back(it);
      host_acc(sel, 1'b0, a, 16'h0, w);
   endtask

   // scoreboard monitors: compare read data just before the completing edge
   always begin
      exp_t e;
      @(negedge clk); #5;
      if (rst_n && core_req && !core_we && core_ack) begin
         if (cq.size() == 0) check("core read unexpected", core_rdata, 16'hxxxx);
         else begin e = cq.pop_front(); check(e.tag, core_rdata, e.v); end
      end
   end
   always begin
      exp_t e;
      @(negedge clk); #5;
      if (rst_n && host_req && !host_we && host_ack) begin
         if (hq.size() == 0) check("host read unexpected", host_rdata, 16'hxxxx);
         else begin e = hq.pop_front(); check(e.tag, host_rdata, e.v); end
      end
   end
   always begin
      exp_t e;
      @(negedge clk); #5;
      if (rst_n && c8_req && !c8_we && c8_ack) begin
         if (c8q.size() == 0) check("core8 read unexpected", c8_rdata, 16'hxxxx);
         else begin e = c8q.pop_front(); check(e.tag, c8_rdata, e.v); end
      end
   end
   always begin
      exp_t e;
      @(negedge clk); #5;
      if (rst_n && h8_req && !h8_we && h8_ack) begin
         if (h8q.size() == 0) check("host8 read unexpected", {8'h00, h8_rdata}, 16'hxxxx);
         else begin e = h8q.pop_front(); check(e.tag, {8'h00, h8_rdata}, {8'h00, e.v[7:0]}); end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      core_rd(0, B + 6, 16'h0000, "R1 flag word after reset");
      core_rd(0, B + 7, 16'h0080, "R1 control word after reset");
      host_rd(0, 4'd6, 16'h0000, "R1 host flag word after reset");
      host_rd(0, 4'd7, 16'h0080, "R1 host control word after reset");

      // R2 R3 R4 R5 core writes, host reads
      core_acc(0, 1, B + 1, 16'hA5A5, w_c);
      core_rd(0, B + 6, 16'h0200, "R3 core flag bit 9");
      core_rd(0, B + 7, 16'h0082, "R4 control mirrors core flags");
      core_rd(0, B + 1, 16'hA5A5, "R2 core reads own slot");
      core_rd(0, B + 6, 16'h0200, "R5 own-side read keeps flag");
      host_rd(0, 4'd1, 16'hA5A5, "R2 host reads slot 1");
      core_rd(0, B + 6, 16'h0000, "R5 host read clears core flag");

      // R5 host writes, core reads
      host_acc(0, 1, 4'd4, 16'h1234, w_h);
      core_rd(0, B + 6, 16'h0010, "R3 host flag bit 4");
      host_rd(0, 4'd4, 16'h1234, "R5 host own read");
      core_rd(0, B + 6, 16'h0010, "R5 host own read keeps flag");
      core_rd(0, B + 4, 16'h1234, "R5 core reads host slot");
      core_rd(0, B + 6, 16'h0000, "R5 core read clears host flag");

      // R9 ignored status writes
      core_acc(0, 1, B + 6, 16'hFFFF, w_c);
      core_rd(0, B + 6, 16'h0000, "R9 flag word write ignored");
      core_acc(0, 1, B + 7, 16'hFF3F, w_c);
      core_rd(0, B + 7, 16'h0000, "R9 only bit 7 takes effect");
      host_acc(0, 1, 4'd7, 16'h0080, w_h);
      host_rd(0, 4'd7, 16'h0080, "R9 host sets overwrite");

      // R6 overwrite on
      core_acc(0, 1, B + 2, 16'h1111, w_c);
      core_acc(0, 1, B + 2, 16'h2222, w_c);
      check("R6 write to flagged slot not stalled", 16'(w_c), 16'd0);
      host_rd(0, 4'd2, 16'h2222, "R6 data replaced");

      // R7 overwrite off
      core_acc(0, 1, B + 7, 16'h0000, w_c);
      core_acc(0, 1, B + 2, 16'hAAAA, w_c);
      fork
         core_acc(0, 1, B + 2, 16'hBBBB, w_c);
         begin
            repeat (3) @(negedge clk);
            #2 check("R7 ack held while unread", {15'd0, core_req && !core_ack}, 16'd1);
            host_rd(0, 4'd2, 16'hAAAA, "R7 old word kept while held");
         end
      join
      host_rd(0, 4'd2, 16'hBBBB, "R7 held write lands after read");
      core_acc(0, 1, B + 7, 16'h0080, w_c);

      // R8 software reset
      core_acc(0, 1, B + 3, 16'h3333, w_c);
      host_acc(0, 1, 4'd0, 16'h0F0F, w_h);
      core_acc(0, 1, B + 7, 16'h00C0, w_c);
      core_rd(0, B + 6, 16'h0801, "R8 flags still old one cycle after");
      core_rd(0, B + 6, 16'h0000, "R8 flags cleared");
      core_rd(0, B + 7, 16'h0080, "R8 reset bit reads zero, overwrite kept");
      core_rd(0, B + 3, 16'h3333, "R8 data kept");

      // R10 simultaneous writes
      fork
         core_acc(0, 1, B + 3, 16'h1111, w_c);
         host_acc(0, 1, 4'd3, 16'h2222, w_h);
      join
      core_rd(0, B + 6, 16'h0808, "R10 both flags set");
      host_rd(0, 4'd3, 16'h1111, "R10 core word wins");
      core_rd(0, B + 3, 16'h1111, "R10 core word wins core view");
      core_rd(0, B + 6, 16'h0000, "R10 flags cleared by reads");

      // R11 set versus clear
      core_acc(0, 1, B + 0, 16'h5555, w_c);
      host_rd(0, 4'd0, 16'h5555, "R11 first word");
      fork
         core_acc(0, 1, B + 0, 16'h6666, w_c);
         host_rd(0, 4'd0, 16'h5555, "R11 reader gets old word");
      join
      core_rd(0, B + 6, 16'h0100, "R11 flag ends set");
      host_rd(0, 4'd0, 16'h6666, "R11 new word");

      // R13 outside window
      core_acc(0, 1, 14'h0005, 16'hDEAD, w_c);
      check("R13 outside write not stalled", 16'(w_c), 16'd0);
      core_rd(0, 14'h0005, 16'h0000, "R13 outside read zero");
      core_rd(0, B + 5, 16'h0000, "R13 slot 5 untouched");
      core_rd(0, B + 6, 16'h0000, "R13 flags untouched");

      // R12 byte-wide host
      core_acc(1, 1, B + 1, 16'hBEEF, w_c);
      host_rd(1, 4'd2, 16'h00EF, "R12 low byte read");
      core_rd(1, B + 6, 16'h0200, "R12 low byte read keeps flag");
      host_rd(1, 4'd3, 16'h00BE, "R12 high byte read");
      core_rd(1, B + 6, 16'h0000, "R12 high byte read clears flag");
      host_acc(1, 1, 4'd8, 16'h0034, w_h);
      core_rd(1, B + 6, 16'h0000, "R12 low byte write sets no flag");
      host_acc(1, 1, 4'd9, 16'h0012, w_h);
      core_rd(1, B + 6, 16'h0010, "R12 high byte write sets flag");
      core_rd(1, B + 4, 16'h1234, "R12 assembled word");
      core_acc(1, 1, B + 0, 16'h0001, w_c);
      host_rd(1, 4'd14, 16'h0081, "R12 R4 control low byte mirror");
      host_rd(1, 4'd12, 16'h0000, "R12 flag low byte");

      repeat (3) @(posedge clk);
      check("queues drained", 16'(cq.size() + hq.size() + c8q.size() + h8q.size()), 16'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule